// File: doc/BRIEF.md
# Chainable Eight-Lane Priority Encoder

The block turns a set of request lines into the binary index of the most important active line. One stage serves eight lanes with fixed ranking: lane 7 wins over every other lane and lane 0 loses to all of them. Each stage has an enable input, a flag that shows whether any lane won, and an enable output. The enable output is high only when the stage is enabled and idle. It feeds the enable of the next less important stage, so any request in a more important stage silences every stage below it.

The top module joins a parameterized number of identical stages into one wide encoder. Stage s serves request bits 8s+7 down to 8s, and the highest stage sits first in the enable chain. The three low index bits are the OR of the per-stage indices. The bits above them give the number of the single stage whose flag is up. All paths are purely combinational.

Top module: `prio_chain`

## Requirements
- R1: Within a stage the index output is the binary number of the highest-numbered active lane (lane 7 gives 3'b111, lane 0 gives 3'b000), whatever the lanes below it carry.
- R2: With the enable input low, the index, the group flag and the enable output are all 0 for every request pattern, in a stage and in the whole chain.
- R3: With enable high and at least one request high, the group flag is 1 and the enable output is 0.
- R4: With enable high and no request high, the group flag is 0, the index is 0 and the enable output is 1.
- R5: In the chain, a request in a stage with a higher number masks every request in lower-numbered stages, so the index depends only on the highest active request bit of the whole input.
- R6: Chain index bits [2:0] are the lane within the winning stage. Bits above bit 2 are the winning stage number, so the full index equals the bit position of the highest active request bit.
- R7: The chain group flag is 1 exactly when enabled with some request bit high. The chain enable output is 1 exactly when enabled with no request bit high, and then the whole index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Chain enable, feeds the highest stage |
| req_i | input | 8*N_STAGES | Request lines, bit 0 least important |
| idx_o | output | 3+clog2(N_STAGES) | Index of the most important active request |
| grp_o | output | 1 | Some request is active while enabled |
| en_o | output | 1 | Enabled and idle; drives a following, less important chain |

## Verification
The critical case is masking and encoding occurring together. This happens when requests are present in an upper and a lower stage at once: the lower stage has to go quiet while the upper stage's number is placed in the top index bits. Random multi-hot words across 16 and 32 lanes, some of them thinned to one or two set bits, make this happen often. Each result is judged against a reference that simply finds the highest set bit of the whole word, so any leak from a masked stage shows up as a wrong index or a wrong flag.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  typedef logic [LANE_W-1:0] lane_idx_t;
endpackage

// File: rtl/prio_stage.sv
module prio_stage
  import prio_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned IW = $clog2(N_LANES)
) (
  input  logic               en_i,
  input  logic [N_LANES-1:0] req_i,
  output logic [IW-1:0]      idx_o,
  output logic               grp_o,
  output logic               en_o
);
  logic [IW-1:0] win;
  logic          hit;

  // scan upward: a later (higher) lane overrides earlier ones
  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = 0; i < int'(N_LANES); i++) begin
      if (req_i[i]) begin
        win = IW'(i);
        hit = 1'b1;
      end
    end
  end

  assign idx_o = en_i ? win : '0;
  assign grp_o = en_i & hit;
  assign en_o  = en_i & ~hit;

  always_comb begin
    if (!en_i) begin
      a_r2_off: assert ({idx_o, grp_o, en_o} == '0) else $error("stage active while disabled");
    end
    if (grp_o) begin
      a_r1_top_lane: assert ((req_i >> idx_o) == N_LANES'(1)) else $error("index is not the top lane");
    end
    a_r3_excl: assert (!(grp_o && en_o)) else $error("group and enable-out both high");
    if (en_i && req_i == '0) begin
      a_r4_idle: assert (en_o && !grp_o && idx_o == '0) else $error("idle stage outputs wrong");
    end
  end
endmodule

// File: rtl/prio_onehot_enc.sv
module prio_onehot_enc #(
  parameter int unsigned N = 2,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] oh_i,
  output logic [W-1:0] bin_o
);
  always_comb begin
    bin_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (oh_i[i]) bin_o = bin_o | W'(i);
    end
  end
endmodule

// File: rtl/prio_chain.sv
module prio_chain
  import prio_pkg::*;
#(
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned SW    = $clog2(N_STAGES),
  localparam int unsigned IDX_W = LANE_W + SW,
  localparam int unsigned REQ_W = LANES * N_STAGES
) (
  input  logic             en_i,
  input  logic [REQ_W-1:0] req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             grp_o,
  output logic             en_o
);
  logic [N_STAGES:0]   en_link;
  logic [N_STAGES-1:0] grp_vec;
  lane_idx_t           lane_idx [N_STAGES];
  lane_idx_t           lane_or;

  assign en_link[N_STAGES] = en_i;

  for (genvar s = 0; s < int'(N_STAGES); s++) begin : g_stage
    prio_stage #(.N_LANES(LANES)) u_stage (
      .en_i (en_link[s+1]),
      .req_i(req_i[s*LANES +: LANES]),
      .idx_o(lane_idx[s]),
      .grp_o(grp_vec[s]),
      .en_o (en_link[s])
    );
  end

  always_comb begin
    lane_or = '0;
    for (int s = 0; s < int'(N_STAGES); s++) lane_or = lane_or | lane_idx[s];
  end

  if (N_STAGES > 1) begin : g_wide
    logic [SW-1:0] stage_num;
    prio_onehot_enc #(.N(N_STAGES)) u_enc (
      .oh_i (grp_vec),
      .bin_o(stage_num)
    );
    assign idx_o = {stage_num, lane_or};
  end else begin : g_single
    assign idx_o = lane_or;
  end

  assign grp_o = |grp_vec;
  assign en_o  = en_link[0];

  always_comb begin
    a_r5_one_winner: assert ($onehot0(grp_vec)) else $error("more than one stage won");
    a_r7_excl: assert (!(grp_o && en_o)) else $error("chain group and enable-out both high");
    if (!en_i) begin
      a_r2_chain_off: assert ({idx_o, grp_o, en_o} == '0) else $error("chain active while disabled");
    end
    if (grp_o) begin
      a_r6_top_bit: assert ((req_i >> idx_o) == REQ_W'(1)) else $error("chain index not top bit");
    end
    if (en_o) begin
      a_r7_idle_zero: assert (idx_o == '0 && req_i == '0) else $error("idle chain outputs wrong");
    end
  end
endmodule

// File: tb/prio_chain_tb.sv
module prio_chain_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        st_en, c2_en, c4_en;
  logic [7:0]  st_req;
  logic [15:0] c2_req;
  logic [31:0] c4_req;
  logic [2:0]  st_idx;
  logic [3:0]  c2_idx;
  logic [4:0]  c4_idx;
  logic        st_grp, st_eo, c2_grp, c2_eo, c4_grp, c4_eo;

  prio_stage u_stage (.en_i(st_en), .req_i(st_req), .idx_o(st_idx), .grp_o(st_grp), .en_o(st_eo));
  prio_chain #(.N_STAGES(2)) u_dut (.en_i(c2_en), .req_i(c2_req), .idx_o(c2_idx), .grp_o(c2_grp), .en_o(c2_eo));
  prio_chain #(.N_STAGES(4)) u_dut4 (.en_i(c4_en), .req_i(c4_req), .idx_o(c4_idx), .grp_o(c4_grp), .en_o(c4_eo));

  typedef struct {
    int         sel;
    logic [4:0] idx;
    logic       grp;
    logic       eo;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference: position of the highest set bit among the low nbits
  function automatic exp_t model(int sel, logic en, logic [31:0] req, int nbits, string tag);
    exp_t e;
    e.sel = sel; e.idx = '0; e.grp = 1'b0; e.eo = 1'b0; e.tag = tag;
    if (en) begin
      e.eo = 1'b1;
      for (int i = nbits - 1; i >= 0; i--) begin
        if (req[i] && !e.grp) begin
          e.idx = 5'(i); e.grp = 1'b1; e.eo = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic drive(int sel, logic en, logic [31:0] req, string tag);
    @(posedge clk);
    #1;
    case (sel)
      0: begin st_en = en; st_req = req[7:0];  q.push_back(model(0, en, req, 8, tag));  end
      1: begin c2_en = en; c2_req = req[15:0]; q.push_back(model(1, en, req, 16, tag)); end
      default: begin c4_en = en; c4_req = req; q.push_back(model(2, en, req, 32, tag)); end
    endcase
  endtask

  initial begin : monitor
    exp_t e;
    logic [4:0] a_idx;
    logic a_grp, a_eo;
    forever begin
      @(negedge clk);
      if (rst_ni && q.size() > 0) begin
        e = q.pop_front();
        case (e.sel)
          0: begin a_idx = {2'b0, st_idx}; a_grp = st_grp; a_eo = st_eo; end
          1: begin a_idx = {1'b0, c2_idx}; a_grp = c2_grp; a_eo = c2_eo; end
          default: begin a_idx = c4_idx; a_grp = c4_grp; a_eo = c4_eo; end
        endcase
        n_tests++;
        if (a_idx !== e.idx || a_grp !== e.grp || a_eo !== e.eo) begin
          n_fail++;
          $display("FAIL %s dut%0d: idx/grp/eo actual %0d/%b/%b expected %0d/%b/%b",
                   e.tag, e.sel, a_idx, a_grp, a_eo, e.idx, e.grp, e.eo);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] r;
    st_en = 0; c2_en = 0; c4_en = 0; st_req = '0; c2_req = '0; c4_req = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R2: disabled state with requests present
    drive(0, 1'b0, 32'hff, "R2");
    drive(1, 1'b0, 32'hffff, "R2");
    drive(2, 1'b0, 32'h8000_0001, "R2");
    // R4 / R7: enabled and idle
    drive(0, 1'b1, 32'h0, "R4");
    drive(1, 1'b1, 32'h0, "R7");
    drive(2, 1'b1, 32'h0, "R7");
    // R1 R3: exhaustive single stage over enable and data
    for (int k = 0; k < 512; k++) drive(0, k[8], 32'(k[7:0]), k[8] ? "R1" : "R2");
    // R6: one-hot sweeps
    for (int b = 0; b < 16; b++) drive(1, 1'b1, 32'h1 << b, "R6");
    for (int b = 0; b < 32; b++) drive(2, 1'b1, 32'h1 << b, "R6");
    // R5: upper and lower stage both busy
    drive(1, 1'b1, 32'h0000_01ff, "R5");
    drive(2, 1'b1, 32'h0100_ffff, "R5");
    drive(2, 1'b1, 32'h0001_0080, "R5");
    // R5 R3: random multi-hot, some thinned
    for (int k = 0; k < 300; k++) begin
      r = $urandom();
      if (k % 3 == 1) r = r & $urandom() & $urandom();
      drive(1, 1'b1, r, "R5");
      drive(2, (k % 17) != 0, r, "R5");
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule